// File: doc/BRIEF.md
# Sleep Wakeup Sequencer

This block brings a system out of a low-power sleep state in a fixed series of steps. While the system sleeps, the block holds a system-wide power-down line and a bus-request line to the CPU asserted. It watches a vector of interrupt requests together with a per-bit enable vector. The first request whose enable bit is set starts a wakeup run. The run is paced by the edges of a slow 32 kHz reference clock. That clock is sampled as data inside one fast system clock domain, and each of its edges turns into a single-cycle enable pulse.

A run goes as follows. A falling slow edge catches the synchronized wake request. The next rising slow edge releases power-down. The rising edge after that captures the bandgap-ready status. The falling edge after that captures the supply-monitor status and drops the bus request. The dropped request reaches the CPU through a two-flop synchronizer. When the CPU lowers its bus acknowledge, a one-cycle done pulse marks the end of the run. A sleep command given while the system runs puts it back to sleep and re-arms the block. The CPU's own global interrupt enable plays no part in the wakeup.

Top module: `sleep_wake_seq`

## Requirements
- R1: After reset, pwr_down, brq, bg_seen, sup_seen and wake_done are all 0 (system running).
- R2: A one-cycle sleep_cmd while running sets pwr_down on the next clock, sets brq within three clocks, and clears bg_seen and sup_seen.
- R3: While asleep, a request bit whose irq_enable bit is 0 has no effect: pwr_down and brq stay 1.
- R4: Any single request bit, at any index, whose irq_enable bit is 1 (1 = allowed) starts a wakeup run.
- R5: pwr_down falls only in the cycle after a detected rising edge of slow_clk, so within six fast clocks of that slow edge.
- R6: bg_seen takes the value of bandgap_ok at the second detected rising slow edge of the run.
- R7: sup_seen takes the value of lvd_ok at the following detected falling slow edge. brq falls at that point, after pwr_down has fallen, and reaches the port two clocks later.
- R8: The time from the request to wake_done lies between two and three slow periods (plus a fixed delay of a few fast clocks). It is near three periods when the request just misses a falling slow edge and near two when it comes just before one.
- R9: A sleep_cmd during a wakeup run is ignored. The run completes and the system stays awake.
- R10: wake_done is a single-cycle pulse, given when cpu_bra falls after brq has been dropped.
- R11: At most one slow-edge enable pulse is active in any fast cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | 32 kHz reference, sampled as data |
| irq_req | input | N_IRQ | Asynchronous interrupt requests |
| irq_enable | input | N_IRQ | Per-request wake enable, 1 = allowed |
| sleep_cmd | input | 1 | Enter sleep (honoured only while running) |
| bandgap_ok | input | 1 | Bandgap-settled status from analog |
| lvd_ok | input | 1 | Supply-monitor status from analog |
| cpu_bra | input | 1 | CPU bus acknowledge |
| pwr_down | output | 1 | System-wide power-down |
| brq | output | 1 | Bus request to the CPU, synchronized |
| bg_seen | output | 1 | Captured bandgap status |
| sup_seen | output | 1 | Captured supply-monitor status |
| wake_done | output | 1 | One-cycle pulse when the CPU resumes |

## Verification
A wrong sequencer state shows at the ports within one slow period. A step taken on the wrong edge moves the fall of pwr_down or brq away from the slow edge the bench expects. A skipped or doubled step pushes the latency out of its two-to-three-period window, or changes the captured status flags. A sequencer that wrongly honours a mask or a sleep command mid-run either leaves pwr_down high for several slow periods or never produces wake_done, and the bench's timeout catches it.

// File: rtl/swk_pkg.sv
package swk_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_ASLEEP  = 3'd1,
    ST_PWRUP   = 3'd2,
    ST_BGAP    = 3'd3,
    ST_SUPPLY  = 3'd4,
    ST_HANDOFF = 3'd5
  } swk_state_e;
endpackage

// File: rtl/swk_sync.sv
module swk_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/swk_edge_det.sv
module swk_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_in,
  output logic rise_en,
  output logic fall_en
);
  logic slow_s;
  logic slow_prev;

  swk_sync #(.WIDTH(1), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(slow_in), .q(slow_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slow_prev <= 1'b0;
    else        slow_prev <= slow_s;
  end

  assign rise_en = slow_s & ~slow_prev;
  assign fall_en = ~slow_s & slow_prev;

  assert_one_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_en, fall_en}));
  assert_rise_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rise_en |=> !rise_en);
endmodule

// File: rtl/swk_fsm.sv
module swk_fsm
  import swk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_en,
  input  logic fall_en,
  input  logic wake_req,
  input  logic sleep_cmd,
  input  logic bandgap_ok,
  input  logic lvd_ok,
  input  logic cpu_bra,
  output logic pwr_down,
  output logic brq_raw,
  output logic bg_seen,
  output logic sup_seen,
  output logic wake_done
);
  swk_state_e state_q, state_d;
  logic pwr_d, brq_d, bg_d, sup_d, done_d;
  logic bra_q;

  always_comb begin
    state_d = state_q;
    pwr_d   = pwr_down;
    brq_d   = brq_raw;
    bg_d    = bg_seen;
    sup_d   = sup_seen;
    done_d  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (sleep_cmd) begin
          state_d = ST_ASLEEP;
          pwr_d   = 1'b1;
          brq_d   = 1'b1;
          bg_d    = 1'b0;
          sup_d   = 1'b0;
        end
      end
      ST_ASLEEP: begin
        if (fall_en && wake_req) state_d = ST_PWRUP;
      end
      ST_PWRUP: begin
        if (rise_en) begin
          state_d = ST_BGAP;
          pwr_d   = 1'b0;
        end
      end
      ST_BGAP: begin
        if (rise_en) begin
          state_d = ST_SUPPLY;
          bg_d    = bandgap_ok;
        end
      end
      ST_SUPPLY: begin
        if (fall_en) begin
          state_d = ST_HANDOFF;
          sup_d   = lvd_ok;
          brq_d   = 1'b0;
        end
      end
      ST_HANDOFF: begin
        if (bra_q && !cpu_bra) begin
          state_d = ST_RUN;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      pwr_down  <= 1'b0;
      brq_raw   <= 1'b0;
      bg_seen   <= 1'b0;
      sup_seen  <= 1'b0;
      wake_done <= 1'b0;
      bra_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      pwr_down  <= pwr_d;
      brq_raw   <= brq_d;
      bg_seen   <= bg_d;
      sup_seen  <= sup_d;
      wake_done <= done_d;
      bra_q     <= cpu_bra;
    end
  end

  assert_asleep_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ASLEEP) |-> (pwr_down && brq_raw));
  assert_pd_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> $past(rise_en));
  assert_brq_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brq_raw) |-> ($past(fall_en) && !pwr_down));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> !wake_done);
  assert_sleep_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUPPLY && sleep_cmd && !fall_en) |=> !pwr_down);
endmodule

// File: rtl/sleep_wake_seq.sv
module sleep_wake_seq #(
  parameter int N_IRQ       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_clk,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_enable,
  input  logic             sleep_cmd,
  input  logic             bandgap_ok,
  input  logic             lvd_ok,
  input  logic             cpu_bra,
  output logic             pwr_down,
  output logic             brq,
  output logic             bg_seen,
  output logic             sup_seen,
  output logic             wake_done
);
  logic rise_en, fall_en;
  logic wake_raw, wake_s;
  logic brq_raw;

  assign wake_raw = |(irq_req & irq_enable);

  swk_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_wake_sync (
    .clk(clk), .rst_n(rst_n), .d(wake_raw), .q(wake_s)
  );

  swk_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .slow_in(slow_clk),
    .rise_en(rise_en), .fall_en(fall_en)
  );

  swk_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .rise_en(rise_en), .fall_en(fall_en),
    .wake_req(wake_s), .sleep_cmd(sleep_cmd), .bandgap_ok(bandgap_ok),
    .lvd_ok(lvd_ok), .cpu_bra(cpu_bra), .pwr_down(pwr_down),
    .brq_raw(brq_raw), .bg_seen(bg_seen), .sup_seen(sup_seen),
    .wake_done(wake_done)
  );

  swk_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_brq_sync (
    .clk(clk), .rst_n(rst_n), .d(brq_raw), .q(brq)
  );

  assert_brq_lags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brq) |-> !pwr_down);
endmodule

// File: tb/sleep_wake_seq_tb.sv
module sleep_wake_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int HALF = 20;
  localparam int P = 2 * HALF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_clk = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic [N-1:0] irq_enable = '0;
  logic sleep_cmd = 1'b0;
  logic bandgap_ok = 1'b1;
  logic lvd_ok = 1'b1;
  logic cpu_bra = 1'b0;
  logic pwr_down, brq, bg_seen, sup_seen, wake_done;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int slow_cnt = 0;
  int last_rise = 0;
  int last_fall = 0;

  sleep_wake_seq #(.N_IRQ(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .irq_req(irq_req),
    .irq_enable(irq_enable), .sleep_cmd(sleep_cmd), .bandgap_ok(bandgap_ok),
    .lvd_ok(lvd_ok), .cpu_bra(cpu_bra), .pwr_down(pwr_down), .brq(brq),
    .bg_seen(bg_seen), .sup_seen(sup_seen), .wake_done(wake_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc = cyc + 1;
    cpu_bra = brq;
    slow_cnt = slow_cnt + 1;
    if (slow_cnt == HALF) begin
      slow_cnt = 0;
      slow_clk = ~slow_clk;
      if (slow_clk) last_rise = cyc; else last_fall = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic go_sleep();
    @(negedge clk); sleep_cmd = 1'b1;
    @(negedge clk); sleep_cmd = 1'b0;
  endtask

  task automatic t_reset();
    wait_clk(2);
    chk(pwr_down == 0 && brq == 0, "R1 pwr_down/brq", {pwr_down, brq}, 0);
    chk(bg_seen == 0 && sup_seen == 0 && wake_done == 0, "R1 flags",
        {bg_seen, sup_seen, wake_done}, 0);
    rst_n = 1'b1;
    wait_clk(3);
  endtask

  task automatic t_sleep();
    go_sleep();
    chk(pwr_down == 1, "R2 pwr_down", pwr_down, 1);
    wait_clk(3);
    chk(brq == 1, "R2 brq", brq, 1);
    chk(bg_seen == 0 && sup_seen == 0, "R2 flags cleared", {bg_seen, sup_seen}, 0);
  endtask

  task automatic t_masked();
    irq_enable = 8'h0F;
    irq_req = 8'hF0;
    wait_clk(3 * P);
    chk(pwr_down == 1 && brq == 1, "R3 masked request", {pwr_down, brq}, 3);
    irq_req = '0;
    wait_clk(4);
  endtask

  // one wakeup run; delay is the number of clocks after a slow falling edge
  task automatic t_wake(input int idx, input int delay, input bit bg, input bit lvd,
                        input bit mid_sleep, output int lat);
    int t0;
    int pd_gap;
    int brq_gap;
    bit pd_seen;
    bit brq_seen_fall;
    bit done_seen;
    bit prev_brq;
    int pulses;
    bandgap_ok = bg;
    lvd_ok = lvd;
    irq_enable = '0;
    irq_enable[idx] = 1'b1;
    @(negedge slow_clk);
    wait_clk(delay);
    irq_req[idx] = 1'b1;
    t0 = cyc;
    pd_seen = 0; brq_seen_fall = 0; done_seen = 0; pulses = 0;
    pd_gap = -1; brq_gap = -1; lat = -1;
    prev_brq = brq;
    for (int i = 0; i < 5 * P && !done_seen; i++) begin
      @(negedge clk);
      if (!pd_seen && !pwr_down) begin
        pd_seen = 1;
        pd_gap = cyc - last_rise;
        if (mid_sleep) begin
          sleep_cmd = 1'b1;
          @(negedge clk);
          sleep_cmd = 1'b0;
        end
      end
      if (prev_brq && !brq) begin
        brq_seen_fall = 1;
        brq_gap = cyc - last_fall;
      end
      prev_brq = brq;
      if (wake_done) begin
        done_seen = 1;
        lat = cyc - t0;
        pulses++;
      end
    end
    irq_req = '0;
    @(negedge clk);
    if (wake_done) pulses++;
    chk(done_seen, "R4 wake by enabled bit", done_seen, 1);
    chk(pd_gap >= 0 && pd_gap <= 6, "R5 pwr_down after slow rise", pd_gap, 4);
    chk(brq_seen_fall && brq_gap <= 8, "R7 brq after slow fall", brq_gap, 6);
    chk(bg_seen == bg, "R6 bandgap captured", bg_seen, bg);
    chk(sup_seen == lvd, "R7 supply captured", sup_seen, lvd);
    chk(lat >= 2 * P && lat <= 3 * P + 12, "R8 latency window", lat, 5 * P / 2);
    chk(pulses == 1, "R10 single done pulse", pulses, 1);
    wait_clk(2 * P);
    chk(pwr_down == 0 && brq == 0, "R9 awake after run", {pwr_down, brq}, 0);
  endtask

  initial begin
    int lat;
    fork
      begin
        t_reset();
        t_sleep();
        t_masked();
        t_wake(0, P - 8, 1'b1, 1'b1, 1'b0, lat);
        chk(lat <= 2 * P + 20, "R8 late request near two periods", lat, 2 * P + 14);
        t_sleep();
        t_wake(N - 1, 4, 1'b0, 1'b1, 1'b0, lat);
        chk(lat >= 3 * P - 4, "R8 early request near three periods", lat, 3 * P + 2);
        t_sleep();
        t_wake(3, 10, 1'b1, 1'b0, 1'b1, lat);
        t_sleep();
        chk(pwr_down == 1, "R2 sleep again after run", pwr_down, 1);
      end
      begin
        wait_clk(150000);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule